// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Modulator

This block produces two independent pulse-width modulated outputs. Each channel divides the system clock by a value chosen with a 4-bit code. It then counts those slow ticks through a programmable period and holds its output at the active level during the first part of each period. All settings live in three 32-bit words that are reached through a word-addressed write port and a combinational read port. Word 0 is a shared control word. Words 1 and 2 hold the count settings of channel 0 and channel 1.

A new count setting is not applied at once. It is parked in a shadow register and moves into the working registers when the running period ends, or on the next clock if the channel is off. While it waits, the channel's pending bit reads 1 and further writes to that count word are dropped. Each channel can also be set for polarity and single-shot operation, and can be frozen through a clock gate. A bypass setting sends the divided clock itself to the pin.

Top module: `dpwm_top`

## Requirements
- R1: After synchronous reset every stored bit is 0: control word and count words read 0, no update is pending, and both outputs are high because a disabled channel with active-state 0 idles high.
- R2: The 4-bit divider code of a channel sets its tick rate. Code 15 gives one tick per clock. Codes 0,1,2,3,4 give 120,180,240,360,480 clocks per tick. Codes 8,9,10,11,12 give 12000,24000,36000,48000,72000. Codes 5,6,7,13,14 give no ticks, so the channel stays in place.
- R3: Let A be the active count and L = stored period + 1. Once a disabled channel is enabled with its gate open, the output is active for the first A ticks of every L ticks, starting with the first clock after the enabling write.
- R4: With active-state bit 1, active means high. With active-state 0, the output is inverted.
- R5: With enable 1 and the gate bit 0, the tick counter and the output freeze. Reopening the gate resumes from the frozen count.
- R6: A disabled channel drives its inactive level. A count write to a disabled channel reads as pending for exactly one clock and then takes effect.
- R7: An active count of 0 gives a constant inactive output. An active count of L or more gives a constant active output.
- R8: A count write to a running channel sets pending bit 28+n of word 0. The old waveform continues until the current period ends, and the new values start at the next period. Count writes made while pending is 1 are ignored.
- R9: With the mode bit 1, setting the pulse bit gives exactly one period of waveform and then the idle level. The hardware then clears the pulse bit.
- R10: With the bypass bit 1, the output is a square wave that starts low on enable and toggles on every tick, with polarity applied.
- R11: Register map. Word 0 holds the channel n fields at bit 15n + k, for k = 0-3 divider code, 4 enable, 5 active state, 6 gate, 7 mode, 8 pulse and 9 bypass. Its unused bits read 0. Word 1+n holds the active count in [7:0] and the period minus one in [23:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Word address of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one word per clock |
| rdata | output | 32 | Read data for addr, combinational |
| pwm_out | output | 2 | Per-channel modulated output |
| upd_pending | output | 2 | Per-channel pending count update |

## Verification
Writes take effect at the clock edge that samples the strobe. Outputs are decoded from registers, so the first sample after the enabling write is tick 0 of the first period. A count write to an idle channel shows as pending at the next falling edge and clears one edge later. A count write to a running channel stays pending until the wrap edge, and the first sample with pending low is tick 0 of the new period. The bench samples every output at falling edges and indexes its expected waveform from the write edge. It waits for the pending flag to fall rather than guessing the wrap cycle.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  // control field layout inside one channel slice
  localparam int CH_STRIDE = 15;
  localparam int FIELD_W   = 10;
  localparam int BUSY_LSB  = 28;
  localparam int PRD_LSB   = 16;
  localparam int PSC_W     = 17;

  typedef struct packed {
    logic       byp;
    logic       pulse;
    logic       mode;
    logic       gate;
    logic       pol;
    logic       en;
    logic [3:0] psc;
  } ch_cfg_t;

  // clocks per tick for a divider code, 0 means stopped
  function automatic logic [PSC_W-1:0] psc_divisor(input logic [3:0] code);
    case (code)
      4'd0:    return PSC_W'(120);
      4'd1:    return PSC_W'(180);
      4'd2:    return PSC_W'(240);
      4'd3:    return PSC_W'(360);
      4'd4:    return PSC_W'(480);
      4'd8:    return PSC_W'(12000);
      4'd9:    return PSC_W'(24000);
      4'd10:   return PSC_W'(36000);
      4'd11:   return PSC_W'(48000);
      4'd12:   return PSC_W'(72000);
      4'd15:   return PSC_W'(1);
      default: return '0;
    endcase
  endfunction

  function automatic logic in_active_phase(input logic [7:0] cnt, input logic [7:0] act);
    return cnt < act;
  endfunction
endpackage

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler
  import dpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       run,
  input  logic [3:0] code,
  output logic       tick,
  output logic       slow_clk
);
  logic [PSC_W-1:0] div;
  logic [PSC_W-1:0] pcnt;
  logic             stopped;

  assign div     = psc_divisor(code);
  assign stopped = (div == '0);
  assign tick    = run && !stopped && (pcnt >= div - PSC_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pcnt     <= '0;
      slow_clk <= 1'b0;
    end else if (tick) begin
      pcnt     <= '0;
      slow_clk <= ~slow_clk;
    end else if (run && !stopped) begin
      pcnt <= pcnt + PSC_W'(1);
    end
  end
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ch_cfg_t          cfg,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] wr_act,
  input  logic [CNT_W-1:0] wr_prd,
  input  logic             tick,
  input  logic             slow_clk,
  output logic             busy,
  output logic [CNT_W-1:0] act_q,
  output logic [CNT_W-1:0] prd_q,
  output logic             wrap,
  output logic             load,
  output logic             pulse_clr,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] sh_act;
  logic [CNT_W-1:0] sh_prd;
  logic             idle;
  logic             step;
  logic             raw;

  assign idle      = cfg.mode && !cfg.pulse;
  assign step      = tick && !idle;
  assign wrap      = step && (cnt == prd_q);
  assign load      = busy && (!cfg.en || idle || wrap);
  assign pulse_clr = wrap && cfg.mode && cfg.pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      act_q  <= '0;
      prd_q  <= '0;
      sh_act <= '0;
      sh_prd <= '0;
      busy   <= 1'b0;
    end else begin
      if (!cfg.en || idle || wrap) cnt <= '0;
      else if (step)               cnt <= cnt + CNT_W'(1);

      if (load) begin
        act_q <= sh_act;
        prd_q <= sh_prd;
        busy  <= 1'b0;
      end else if (prd_wr && !busy) begin
        sh_act <= wr_act;
        sh_prd <= wr_prd;
        busy   <= 1'b1;
      end
    end
  end

  assign raw   = cfg.en && (cfg.byp ? slow_clk : (!idle && in_active_phase(cnt, act_q)));
  assign pwm_o = cfg.pol ? raw : ~raw;
endmodule

// File: rtl/dpwm_regbank.sv
module dpwm_regbank
  import dpwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NCH-1:0]             pulse_clr,
  input  logic [NCH-1:0]             busy,
  input  logic [NCH-1:0][CNT_W-1:0]  act_q,
  input  logic [NCH-1:0][CNT_W-1:0]  prd_q,
  output ch_cfg_t [NCH-1:0]          cfg,
  output logic [NCH-1:0]             prd_wr,
  output logic [DATA_W-1:0]          rdata
);
  ch_cfg_t [NCH-1:0] cfg_q;
  logic              ctl_wr;
  logic              unused_wbits;

  assign ctl_wr       = wr_en && (addr == '0);
  assign unused_wbits = ^wdata;
  assign cfg          = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (ctl_wr) cfg_q[n] <= ch_cfg_t'(wdata[n*CH_STRIDE +: FIELD_W]);
        if (pulse_clr[n]) cfg_q[n].pulse <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_wsel
    assign prd_wr[g] = wr_en && (addr == ADDR_W'(g + 1));
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) begin
      for (int n = 0; n < NCH; n++) begin
        rdata[n*CH_STRIDE +: FIELD_W] = cfg_q[n];
        rdata[BUSY_LSB + n]           = busy[n];
      end
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (addr == ADDR_W'(n + 1)) begin
          rdata[CNT_W-1:0]         = act_q[n];
          rdata[PRD_LSB +: CNT_W]  = prd_q[n];
        end
      end
    end
  end
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
  import dpwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    upd_pending
);
  ch_cfg_t [NCH-1:0]         cfg;
  logic [NCH-1:0]            busy;
  logic [NCH-1:0]            tick;
  logic [NCH-1:0]            slow_clk;
  logic [NCH-1:0]            wrap;
  logic [NCH-1:0]            load;
  logic [NCH-1:0]            pulse_clr;
  logic [NCH-1:0]            prd_wr;
  logic [NCH-1:0][CNT_W-1:0] act_q;
  logic [NCH-1:0][CNT_W-1:0] prd_q;

  dpwm_regbank #(
    .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pulse_clr(pulse_clr), .busy(busy), .act_q(act_q), .prd_q(prd_q),
    .cfg(cfg), .prd_wr(prd_wr), .rdata(rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dpwm_prescaler u_psc (
      .clk(clk), .rst(rst), .en(cfg[g].en), .run(cfg[g].en && cfg[g].gate),
      .code(cfg[g].psc), .tick(tick[g]), .slow_clk(slow_clk[g])
    );

    dpwm_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .cfg(cfg[g]), .prd_wr(prd_wr[g]),
      .wr_act(wdata[CNT_W-1:0]), .wr_prd(wdata[PRD_LSB +: CNT_W]),
      .tick(tick[g]), .slow_clk(slow_clk[g]), .busy(busy[g]),
      .act_q(act_q[g]), .prd_q(prd_q[g]), .wrap(wrap[g]), .load(load[g]),
      .pulse_clr(pulse_clr[g]), .pwm_o(pwm_out[g])
    );
  end

  assign upd_pending = busy;
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker
  import dpwm_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input ch_cfg_t [NCH-1:0]         cfg,
  input logic [NCH-1:0]            busy,
  input logic [NCH-1:0]            tick,
  input logic [NCH-1:0]            wrap,
  input logic [NCH-1:0]            load,
  input logic [NCH-1:0]            pulse_clr,
  input logic [NCH-1:0]            prd_wr,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0][CNT_W-1:0] act_q
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r6_disabled_idle: assert property (@(posedge clk) disable iff (rst)
      !cfg[g].en |-> (pwm_out[g] == !cfg[g].pol));

    a_r2_reserved_no_tick: assert property (@(posedge clk) disable iff (rst)
      (psc_divisor(cfg[g].psc) == '0) |-> !tick[g]);

    a_r5_gate_freeze: assert property (@(posedge clk) disable iff (rst)
      (cfg[g].en && !cfg[g].gate) |-> !tick[g]);

    a_r8_pending_holds: assert property (@(posedge clk) disable iff (rst)
      (busy[g] && !load[g]) |=> busy[g]);

    a_r8_ignored_write: assert property (@(posedge clk) disable iff (rst)
      (busy[g] && prd_wr[g] && !load[g]) |=> $stable(act_q[g]));

    a_r8_load_at_wrap: assert property (@(posedge clk) disable iff (rst)
      (load[g] && cfg[g].en && !(cfg[g].mode && !cfg[g].pulse)) |-> wrap[g]);

    a_r7_zero_active: assert property (@(posedge clk) disable iff (rst)
      (cfg[g].en && !cfg[g].byp && act_q[g] == '0) |-> (pwm_out[g] == !cfg[g].pol));

    a_r9_pulse_cleared: assert property (@(posedge clk) disable iff (rst)
      pulse_clr[g] |=> !cfg[g].pulse);
  end
endmodule

bind dpwm_top dpwm_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg(cfg), .busy(busy), .tick(tick), .wrap(wrap),
  .load(load), .pulse_clr(pulse_clr), .prd_wr(prd_wr), .pwm_out(pwm_out),
  .act_q(act_q)
);

// File: tb/tb_dpwm_top.sv
module tb_dpwm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rdata;
  logic [1:0]  pwm_out;
  logic [1:0]  upd_pending;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dpwm_top dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .pwm_out(pwm_out), .upd_pending(upd_pending)
  );

  function automatic int div_of(input int code);
    int tbl [16] = '{120, 180, 240, 360, 480, 0, 0, 0,
                     12000, 24000, 36000, 48000, 72000, 0, 0, 1};
    return tbl[code];
  endfunction

  function automatic logic [31:0] ctl(input int ch, input int code, input bit en, input bit pol,
                                      input bit gate, input bit mode, input bit pulse, input bit byp);
    logic [31:0] f;
    f = 32'(code & 15) | (32'(en) << 4) | (32'(pol) << 5) | (32'(gate) << 6) |
        (32'(mode) << 7) | (32'(pulse) << 8) | (32'(byp) << 9);
    return f << (15 * ch);
  endfunction

  function automatic logic [31:0] cnt_word(input int act, input int prd_m1);
    return (32'(prd_m1 & 255) << 16) | 32'(act & 255);
  endfunction

  function automatic logic exp_level(input int i, input int d, input int a, input int p,
                                     input bit pol, input bit byp);
    logic on;
    int ph;
    ph = i / d;
    if (byp) on = (ph % 2) == 1;
    else     on = (ph % p) < a;
    return pol ? on : !on;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = '0;
  endtask

  task automatic check_wave(input int ch, input int d, input int a, input int p, input bit pol,
                            input bit byp, input int n, input string tag);
    int bad;
    logic g, e;
    bad = -1; g = 1'b0; e = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (bad < 0 && pwm_out[ch] !== exp_level(i, d, a, p, pol, byp)) begin
        bad = i; g = pwm_out[ch]; e = exp_level(i, d, a, p, pol, byp);
      end
      @(negedge clk);
    end
    nchk++;
    if (bad >= 0) begin
      nfail++;
      $display("FAIL %s ch%0d sample %0d got %b exp %b", tag, ch, bad, g, e);
    end
  endtask

  // bring channel to a clean disabled state with fresh counts
  task automatic setup(input int ch, input int act, input int prd_m1);
    wr(2'd0, 32'd0);
    wr(2'(ch + 1), cnt_word(act, prd_m1));
  endtask

  initial begin
    logic [31:0] r;
    int seed;
    seed = $urandom(32'd7919);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(pwm_out === 2'b11, "R1 outputs idle high", 32'(pwm_out), 32'd3);
    check(upd_pending === 2'b00, "R1 nothing pending", 32'(upd_pending), 32'd0);
    rd(2'd0, r); check(r === 32'd0, "R1 control word", r, 32'd0);
    rd(2'd1, r); check(r === 32'd0, "R1 count word ch0", r, 32'd0);
    rd(2'd2, r); check(r === 32'd0, "R1 count word ch1", r, 32'd0);

    // R6 count write to a disabled channel: pending for one clock
    wr(2'd1, cnt_word(1, 3));
    check(upd_pending[0] === 1'b1, "R6 pending after write", 32'(upd_pending), 32'd1);
    @(negedge clk);
    check(upd_pending[0] === 1'b0, "R6 pending cleared", 32'(upd_pending), 32'd0);
    rd(2'd1, r); check(r === 32'h0003_0001, "R11 count word layout", r, 32'h0003_0001);

    // R3 R4 basic waveform, active high, one tick per clock
    wr(2'd0, ctl(0, 15, 1, 1, 1, 0, 0, 0));
    check_wave(0, 1, 1, 4, 1, 0, 40, "R3 basic wave");
    check(pwm_out[1] === 1'b1, "R6 other channel idle", 32'(pwm_out[1]), 32'd1);

    // R11 field readback, unused bits read zero
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, r); check(r === 32'h01FF_83FF, "R11 control readback", r, 32'h01FF_83FF);

    // R4 inverted polarity
    setup(0, 2, 4);
    wr(2'd0, ctl(0, 15, 1, 0, 1, 0, 0, 0));
    check_wave(0, 1, 2, 5, 0, 0, 30, "R4 inverted wave");

    // R7 constant levels
    setup(1, 0, 2);
    wr(2'd0, ctl(1, 15, 1, 1, 1, 0, 0, 0));
    check_wave(1, 1, 0, 3, 1, 0, 30, "R7 zero active");
    setup(1, 9, 2);
    wr(2'd0, ctl(1, 15, 1, 1, 1, 0, 0, 0));
    check_wave(1, 1, 9, 3, 1, 0, 30, "R7 full active");

    // R2 R3 constrained random waveforms
    for (int k = 0; k < 10; k++) begin
      int ch, code, a, pm, d;
      bit pol;
      int codes [4] = '{15, 15, 0, 1};
      ch = $urandom_range(1, 0);
      code = codes[$urandom_range(3, 0)];
      a = $urandom_range(5, 0);
      pm = $urandom_range(3, 0);
      pol = 1'($urandom_range(1, 0));
      d = div_of(code);
      setup(ch, a, pm);
      wr(2'd0, ctl(ch, code, 1, pol, 1, 0, 0, 0));
      check_wave(ch, d, a, pm + 1, pol, 0, d * (pm + 1) * 2, "R3 random wave");
    end

    // R2 slow divider codes
    setup(0, 1, 1);
    wr(2'd0, ctl(0, 4, 1, 1, 1, 0, 0, 0));
    check_wave(0, 480, 1, 2, 1, 0, 1920, "R2 code 4");
    setup(0, 1, 1);
    wr(2'd0, ctl(0, 8, 1, 1, 1, 0, 0, 0));
    check_wave(0, 12000, 1, 2, 1, 0, 24010, "R2 code 8");

    // R2 reserved codes stop the channel
    setup(0, 2, 3);
    wr(2'd0, ctl(0, 5, 1, 1, 1, 0, 0, 0));
    check_wave(0, 1000000, 2, 4, 1, 0, 300, "R2 reserved code 5");
    setup(0, 2, 3);
    wr(2'd0, ctl(0, 14, 1, 1, 1, 0, 0, 0));
    check_wave(0, 1000000, 2, 4, 1, 0, 300, "R2 reserved code 14");

    // R5 gate freeze and resume
    setup(0, 2, 7);
    wr(2'd0, ctl(0, 15, 1, 1, 1, 0, 0, 0));
    repeat (5) @(negedge clk);
    wr(2'd0, ctl(0, 15, 1, 1, 0, 0, 0, 0));
    check_wave(0, 1000000, 0, 1, 1, 0, 50, "R5 frozen");
    wr(2'd0, ctl(0, 15, 1, 1, 1, 0, 0, 0));
    check(pwm_out[0] === 1'b0, "R5 resume last count", 32'(pwm_out[0]), 32'd0);
    @(negedge clk);
    check(pwm_out[0] === 1'b1, "R5 resume wraps", 32'(pwm_out[0]), 32'd1);

    // R8 buffered update on a running channel
    setup(0, 2, 7);
    wr(2'd0, ctl(0, 15, 1, 1, 1, 0, 0, 0));
    repeat (2) @(negedge clk);
    wr(2'd1, cnt_word(1, 3));
    check(upd_pending[0] === 1'b1, "R8 pending port", 32'(upd_pending), 32'd1);
    rd(2'd0, r); check(r[28] === 1'b1, "R8 pending bit 28", r, 32'h1000_0000);
    wr(2'd1, cnt_word(5, 9));
    begin
      int guard;
      guard = 0;
      while (upd_pending[0] === 1'b1 && guard < 50) begin
        @(negedge clk);
        guard++;
      end
      check(guard <= 4, "R8 pending clears at period end", 32'(guard), 32'd2);
    end
    check_wave(0, 1, 1, 4, 1, 0, 16, "R8 new period applied");
    rd(2'd1, r); check(r === 32'h0003_0001, "R8 write while pending ignored", r, 32'h0003_0001);

    // R9 single pulse on channel 1
    setup(1, 2, 4);
    wr(2'd0, ctl(1, 15, 1, 1, 1, 1, 1, 0));
    check_wave(1, 1, 2, 5, 1, 0, 5, "R9 one period");
    check_wave(1, 1000000, 0, 1, 1, 0, 20, "R9 idle after pulse");
    rd(2'd0, r);
    check(r[23] === 1'b0 && r[19] === 1'b1, "R9 pulse bit cleared", r, ctl(1, 15, 1, 1, 1, 1, 0, 0));

    // R10 bypass
    setup(0, 1, 3);
    wr(2'd0, ctl(0, 15, 1, 0, 1, 0, 0, 1));
    check_wave(0, 1, 0, 1, 0, 1, 40, "R10 bypass div 1 inverted");
    setup(0, 1, 3);
    wr(2'd0, ctl(0, 0, 1, 1, 1, 0, 0, 1));
    check_wave(0, 120, 0, 1, 1, 1, 480, "R10 bypass div 120");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired got running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule